// File: doc/BRIEF.md
# Edge Capture Timer with Flag Register

This block is a free-running up-counter with a single capture input. A qualified edge on that input copies the running count into a capture register and raises a capture flag. The counter returns to zero after it reaches a programmable period and raises an update flag when it does. Software reads the flags, enables them onto one level-sensitive interrupt line, and can route capture events to a DMA request instead.

A slave reset mode makes each capture edge also clear the counter. In this mode every captured value is the interval since the previous edge, less a fixed two-count offset. The input is resynchronised before edge detection, so the capture and the reset see the same delay. Status bits are cleared by writing zero and are unchanged by writing one. Software can therefore clear exactly the flags it has seen without losing one that arrives in the meantime.

Top module: `edge_capture_timer`

Register map (word address on `bus_addr`):
- 0 control: bit0 run, bit1 falling-edge select, bit2 slave reset.
- 1 enables: bit0 capture irq, bit1 update irq, bit2 trigger irq, bit3 capture DMA.
- 2 status: bit0 capture, bit1 update, bit2 trigger, bit3 overcapture.
- 3 period.
- 4 count (read only).
- 5 captured value (read only).

## Requirements
- R1: While running, a qualified edge copies the count into the captured-value register (address 5) and sets status bit0.
- R2: The count never exceeds the period (address 3). The count goes to zero in the cycle after it equals the period, and status bit1 is set then.
- R3: A write to status (address 2) clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R4: A capture taken while status bit0 is already set also sets status bit3 (overcapture).
- R5: `irq` is high exactly while some status bit among bit0..bit2 is set with its matching enable bit (address 1, bits 0..2). It falls in the cycle after the last enabled flag is cleared.
- R6: `dma_req` is status bit0 gated by enable bit3, independent of enable bit0. A `dma_ack` pulse clears status bit0, and so does a read of address 5.
- R7: With control bit2 set, each capture edge sets status bit2 and zeroes the count one cycle later. Two edges N cycles apart therefore capture N-2.
- R8: `cap_in` passes a 2-flop synchronizer. Control bit1 selects a falling edge (1) or a rising edge (0), and the other edge is ignored. Status bit0 appears 3 clock edges after the input changes.
- R9: When hardware sets a status bit in the same cycle software writes 0 to it, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 1 | Asynchronous capture input |
| dma_ack | input | 1 | DMA acknowledge, clears capture flag |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Combinational read data |
| irq | output | 1 | Level interrupt |
| dma_req | output | 1 | Capture DMA request |

## Verification
An input change reaches status bit0 on the third rising clock edge. The slave counter reset shows on the fourth. A register write or a `dma_ack` pulse acts on the next edge, and `irq` and `dma_req` follow the flags in that same cycle. The bench drives on falling edges and samples read data 1 ns later, so it counts the rising edges between a stimulus and its check. It probes one cycle before and one cycle on the due edge for the capture latency. For the flag-collision case it lines up a clearing write with the exact wrap edge, using a count readback.

// File: rtl/edge_capture_timer.sv
module edge_capture_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_in,
  input  logic          dma_ack,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq,
  output logic          dma_req
);
  localparam logic [2:0] A_CTRL = 3'd0, A_ENA = 3'd1, A_STAT = 3'd2,
                         A_PER = 3'd3, A_CNT = 3'd4, A_CAP = 3'd5;

  logic [2:0]    sync;
  logic          run, falling, slave, pend;
  logic [3:0]    ena;
  logic [CW-1:0] period, cnt, capv;
  logic          capf, updf, trgf, ovcf;

  wire rise    = sync[1] & ~sync[2];
  wire fall    = ~sync[1] & sync[2];
  wire hit     = run & (falling ? fall : rise);
  wire wrap    = run & ~pend & (cnt >= period);
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire rd_cap  = bus_rd && bus_addr == A_CAP;
  wire [3:0] zap = wr_stat ? ~bus_wdata[3:0] : 4'b0;

  assign irq     = |({trgf, updf, capf} & ena[2:0]);
  assign dma_req = capf & ena[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= '0;
      {run, falling, slave, pend} <= '0;
      ena <= '0;
      period <= '1;
      cnt <= '0;
      capv <= '0;
      {capf, updf, trgf, ovcf} <= '0;
    end else begin
      sync <= {sync[1:0], cap_in};
      pend <= hit & slave;
      if (pend || wrap) cnt <= '0;
      else if (run) cnt <= cnt + 1'b1;
      if (hit) capv <= cnt;
      capf <= hit | (capf & ~zap[0] & ~rd_cap & ~dma_ack);
      updf <= wrap | (updf & ~zap[1]);
      trgf <= (hit & slave) | (trgf & ~zap[2]);
      ovcf <= (hit & capf) | (ovcf & ~zap[3]);
      if (bus_wr && bus_addr == A_CTRL) {slave, falling, run} <= bus_wdata[2:0];
      if (bus_wr && bus_addr == A_ENA) ena <= bus_wdata[3:0];
      if (bus_wr && bus_addr == A_PER) period <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[2:0] = {slave, falling, run};
      A_ENA:  bus_rdata[3:0] = ena;
      A_STAT: bus_rdata[3:0] = {ovcf, trgf, updf, capf};
      A_PER:  bus_rdata = period;
      A_CNT:  bus_rdata = cnt;
      A_CAP:  bus_rdata = capv;
      default: bus_rdata = '0;
    endcase
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> capf && capv == $past(cnt));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pend && cnt == period) |=> cnt == '0 && updf);
  assert_overcap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && capf) |=> ovcf);
  assert_dma_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && !hit) |=> !dma_req);
  assert_slave_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && slave) |=> ##1 (cnt == '0 || pend));
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && wr_stat) |=> updf);
endmodule

// File: tb/sim_edge_capture_timer.sv
module sim_edge_capture_timer;
  logic clk = 0, rst_n = 0, cap_in = 0, dma_ack = 0, bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic irq, dma_req;
  int checks = 0, errors = 0;

  edge_capture_timer #(.CW(16)) u0 (.clk(clk), .rst_n(rst_n), .cap_in(cap_in),
    .dma_ack(dma_ack), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req));

  always #10 clk = ~clk;

  function automatic int exp_interval(input int n); return n - 2; endfunction
  function automatic logic bitof(input logic [15:0] v, input int b); return v[b]; endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, c;
    int prev_n, n, d;
    void'($urandom(32'd4242));
    waitn(3); rst_n = 1; waitn(1);

    rd(3'd2, v); check("R3 reset status", v, 16'h0);
    check("R5 reset irq", {15'b0, irq}, 16'h0);
    check("R6 reset dma_req", {15'b0, dma_req}, 16'h0);

    wr(3'd3, 16'd50); wr(3'd0, 16'h1);
    for (int i = 0; i < 20; i++) begin
      rd(3'd4, v); check("R2 count within period", {15'b0, v <= 16'd50}, 16'h1);
      waitn($urandom % 37);
    end
    wr(3'd2, 16'h0); waitn(55);
    rd(3'd2, v); check("R2 update flag after wrap", {15'b0, bitof(v, 1)}, 16'h1);

    do begin wr(3'd2, 16'h0); rd(3'd4, c); end while (c > 16'd45);
    d = 50 - (c + 1);
    waitn(d); wr(3'd2, 16'h0);
    rd(3'd2, v); check("R9 set wins over write-zero", {15'b0, bitof(v, 1)}, 16'h1);

    wr(3'd3, 16'hFFFF);
    cap_in = 1; waitn(5);
    wr(3'd2, 16'hFFFD);
    rd(3'd2, v); check("R3 write-zero clears, write-one keeps", {14'b0, v[1:0]}, 16'h1);
    wr(3'd2, 16'hFFFF);
    rd(3'd2, v); check("R3 write-one keeps capture flag", {15'b0, bitof(v, 0)}, 16'h1);

    cap_in = 0; waitn(3); cap_in = 1; waitn(5);
    rd(3'd2, v); check("R4 overcapture flag", {15'b0, bitof(v, 3)}, 16'h1);
    rd(3'd5, v);
    rd(3'd2, v); check("R6 capture read clears flag", {15'b0, bitof(v, 0)}, 16'h0);

    wr(3'd1, 16'h8);
    cap_in = 0; waitn(3); cap_in = 1; waitn(5);
    check("R5 capture irq disabled", {15'b0, irq}, 16'h0);
    check("R6 dma request with irq off", {15'b0, dma_req}, 16'h1);
    dma_ack = 1; waitn(1); dma_ack = 0;
    check("R6 dma_ack drops request", {15'b0, dma_req}, 16'h0);
    rd(3'd2, v); check("R6 dma_ack clears flag", {15'b0, bitof(v, 0)}, 16'h0);

    wr(3'd1, 16'h2); wr(3'd2, 16'h0); wr(3'd3, 16'd20); waitn(25);
    check("R5 update irq asserted", {15'b0, irq}, 16'h1);
    wr(3'd2, 16'hFFFD);
    check("R5 irq falls after clear", {15'b0, irq}, 16'h0);
    wr(3'd3, 16'hFFFF); wr(3'd1, 16'h0);

    wr(3'd0, 16'h3); wr(3'd2, 16'h0);
    cap_in = 0; waitn(5);
    rd(3'd2, v); check("R8 falling edge captured", {15'b0, bitof(v, 0)}, 16'h1);
    wr(3'd2, 16'h0);
    cap_in = 1; waitn(5);
    rd(3'd2, v); check("R8 rising edge ignored in falling mode", {15'b0, bitof(v, 0)}, 16'h0);

    wr(3'd0, 16'h1); cap_in = 0; waitn(4); wr(3'd2, 16'h0);
    cap_in = 1; waitn(2);
    peek(3'd2, v); check("R8 flag not yet set at edge 2", {15'b0, bitof(v, 0)}, 16'h0);
    waitn(1);
    peek(3'd2, v); check("R1 flag set at edge 3", {15'b0, bitof(v, 0)}, 16'h1);
    waitn(1);
    peek(3'd5, c); peek(3'd4, v);
    check("R1 captured value trails count", {15'b0, v == c + 16'd2}, 16'h1);

    cap_in = 0; waitn(4); wr(3'd2, 16'h0); wr(3'd0, 16'h5);
    prev_n = 0;
    for (int i = 0; i < 30; i++) begin
      n = 12 + ($urandom % 180);
      cap_in = 1; waitn(4);
      peek(3'd4, v); check("R7 counter reset after edge", v, 16'h0);
      rd(3'd5, v);
      if (i > 0) check("R7 interval capture", v, 16'(exp_interval(prev_n)));
      waitn(n / 2 - 5);
      cap_in = 0; waitn(n - n / 2);
      prev_n = n;
    end
    rd(3'd2, v);
    check("R7 trigger flag set", {15'b0, bitof(v, 2)}, 16'h1);
    check("R4 no overcapture when serviced", {15'b0, bitof(v, 3)}, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule